// File: doc/BRIEF.md
# Per-Register Vector-Length Issue Sequencer

This block sits between instruction decode and a small integer register file with its ALU. Every register carries its own vector length, and an instruction written in plain scalar form (operation, destination, two sources) is expanded into element operations that run one per cycle. A register tagged with length N stands for itself and the N-1 registers above it, so vectors live in the main register file and stay readable as ordinary scalars once their length is set back to 1.

The mix of operand lengths selects the form. When all lengths are 1, the instruction is a plain scalar operation. When the destination and its sources have equal lengths, it is element-wise. When a length-1 source is paired with a vector, that source is reused for every element. When the destination has length 1 and a source is a vector, the instruction is a reduction folded into a single register. Instructions that would run past the last register, that mix vector lengths, or that reduce with subtraction are rejected before they touch any state.

A second register-file port writes data from the rest of the core. A read port lets that data be observed.

Top module: `vl_issue_seq`

## Requirements
- R1: After reset, every register holds 0, every vector length is 1, in_ready is high, and busy, done and illegal are low.
- R2: Operation codes are 0 ADD, 1 SUB, 2 MUL (low 32 bits of the product) and 3 XOR. With all lengths 1, one element is written to the destination.
- R3: When the destination length N is greater than 1 and each source has length N or 1, element i writes register rd+i from source registers rs1+i and rs2+i. Elements run in ascending order, and each one reads the register file as the earlier elements left it.
- R4: A source of length 1 combined with a destination of length N greater than 1 supplies the same register as the operand for every element, in either the first or the second source position.
- R5: A destination of length 1 with a vector source is a reduction. The elements of rs1 (in order), then the elements of rs2, are folded left with the operation into an accumulator that starts at the first rs1 element. Only rd is written, and only once, on the last step.
- R6: A reduction requested with SUB is rejected as illegal.
- R7: If any operand range (base plus length) reaches past register 31, the instruction is rejected. A rejected instruction pulses illegal for exactly one cycle after acceptance, starts no sequence and leaves the register file unchanged. A range that ends exactly at register 31, including a length of 32 starting at r0, is legal.
- R8: Two vector operands (length greater than 1) with different lengths are rejected as illegal. This covers destination against source and the two sources of a reduction.
- R9: A legal instruction keeps busy high and in_ready low for exactly N cycles in element-wise form, or for len(rs1)+len(rs2)-1 cycles in reduction form. done pulses high for one cycle, in the first cycle after the final write.
- R10: Lengths are independent per register, and ranges may overlap. With r0 at length 16 and r7 at length 5, an instruction on r7 changes only r7..r11, and an instruction on r0 may follow it at once.
- R11: Setting a length back to 1 restores scalar behaviour. Element results stay readable through the read port as ordinary registers.
- R12: A length write of 0 is stored as 1. Lengths are captured when an instruction is accepted, so a length write during a running sequence does not change it.
- R13: A register-file write through the write port is ignored while busy is high and takes effect when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Vector-length write enable |
| cfg_reg | input | 5 | Register whose length is written |
| cfg_len | input | 6 | New length (0 is stored as 1) |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Sequencer can accept an instruction |
| in_op | input | 2 | Operation code |
| in_rd | input | 5 | Destination register |
| in_rs1 | input | 5 | First source register |
| in_rs2 | input | 5 | Second source register |
| rf_we | input | 1 | Register-file data write enable |
| rf_waddr | input | 5 | Data write address |
| rf_wdata | input | 32 | Data write value |
| rf_raddr | input | 5 | Read address |
| rf_rdata | output | 32 | Read data (combinational) |
| busy | output | 1 | Element sequence in progress |
| done | output | 1 | One-cycle pulse after the last element write |
| illegal | output | 1 | One-cycle pulse for a rejected instruction |

## Verification
The bench builds the block with its default 32 registers of 32 bits. This makes register 31 the real end of every range, so a vector that ends exactly on the last register, one that overruns it by one, and a single 32-long vector spanning the whole file can all be exercised. The 32-bit width lets multiply chains and reductions wrap, so truncation of the product is checked as well. Overlapping ranges, reductions that mix a vector with a scalar, and length or data writes landing in the middle of a sequence are all compared against a sequential model kept in the bench.

// File: rtl/vl_issue_seq.sv
module vl_issue_seq #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  localparam int AW = $clog2(NREG),
  localparam int LW = AW + 1,
  localparam int CW = LW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_reg,
  input  logic [LW-1:0]   cfg_len,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_op,
  input  logic [AW-1:0]   in_rd,
  input  logic [AW-1:0]   in_rs1,
  input  logic [AW-1:0]   in_rs2,
  input  logic            rf_we,
  input  logic [AW-1:0]   rf_waddr,
  input  logic [XLEN-1:0] rf_wdata,
  input  logic [AW-1:0]   rf_raddr,
  output logic [XLEN-1:0] rf_rdata,
  output logic            busy,
  output logic            done,
  output logic            illegal
);

  localparam logic [1:0] OP_ADD = 2'd0;
  localparam logic [1:0] OP_SUB = 2'd1;
  localparam logic [1:0] OP_MUL = 2'd2;
  localparam logic [LW-1:0] ONE = LW'(1);

  function automatic logic [XLEN-1:0] alu(input logic [1:0] f,
                                          input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] b);
    case (f)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return a * b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic span_bad(input logic [AW-1:0] base,
                                    input logic [LW-1:0] len);
    return (CW'(base) + CW'(len)) > CW'(NREG);
  endfunction

  logic [XLEN-1:0] rf   [NREG];
  logic [LW-1:0]   vlen [NREG];

  logic            run, red;
  logic [1:0]      op;
  logic [AW-1:0]   rd, rs1, rs2;
  logic [LW-1:0]   l1, l2;
  logic [CW-1:0]   cnt, last;
  logic [XLEN-1:0] acc;

  logic [LW-1:0] dl, sl1, sl2;
  logic          v1, v2, red_in, mism, bad, accept;

  assign dl  = vlen[in_rd];
  assign sl1 = vlen[in_rs1];
  assign sl2 = vlen[in_rs2];
  assign v1  = sl1 > ONE;
  assign v2  = sl2 > ONE;

  assign red_in = (dl == ONE) && (v1 || v2);
  assign mism   = (v1 && v2 && sl1 != sl2) ||
                  (!red_in && ((v1 && sl1 != dl) || (v2 && sl2 != dl)));
  assign bad    = span_bad(in_rd, dl) || span_bad(in_rs1, sl1) ||
                  span_bad(in_rs2, sl2) || mism ||
                  (red_in && in_op == OP_SUB);
  assign accept = in_valid && !run;

  logic [AW-1:0]   ia, ib, iw, ie;
  logic [CW-1:0]   roff;
  logic [XLEN-1:0] ew, rv;
  logic            fin;

  assign iw   = rd + cnt[AW-1:0];
  assign ia   = rs1 + ((l1 > ONE) ? cnt[AW-1:0] : '0);
  assign ib   = rs2 + ((l2 > ONE) ? cnt[AW-1:0] : '0);
  assign roff = cnt - CW'(l1);
  assign ie   = (cnt < CW'(l1)) ? rs1 + cnt[AW-1:0] : rs2 + roff[AW-1:0];
  assign ew   = alu(op, rf[ia], rf[ib]);
  assign rv   = alu(op, acc, rf[ie]);
  assign fin  = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (run) begin
      if (!red)     rf[iw] <= ew;
      else if (fin) rf[rd] <= rv;
    end else if (rf_we) begin
      rf[rf_waddr] <= rf_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) vlen[i] <= ONE;
    end else if (cfg_we) begin
      vlen[cfg_reg] <= (cfg_len == '0) ? ONE : cfg_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      red     <= 1'b0;
      op      <= '0;
      rd      <= '0;
      rs1     <= '0;
      rs2     <= '0;
      l1      <= ONE;
      l2      <= ONE;
      cnt     <= '0;
      last    <= '0;
      acc     <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= fin;
      illegal <= accept && bad;
      if (accept && !bad) begin
        run  <= 1'b1;
        red  <= red_in;
        op   <= in_op;
        rd   <= in_rd;
        rs1  <= in_rs1;
        rs2  <= in_rs2;
        l1   <= sl1;
        l2   <= sl2;
        cnt  <= red_in ? CW'(1) : '0;
        last <= red_in ? CW'(sl1) + CW'(sl2) - CW'(1) : CW'(dl) - CW'(1);
        acc  <= rf[in_rs1];
      end else if (run) begin
        if (fin) run <= 1'b0;
        else     cnt <= cnt + CW'(1);
        acc <= rv;
      end
    end
  end

  assign in_ready = !run;
  assign busy     = run;
  assign rf_rdata = rf[rf_raddr];

endmodule

// File: rtl/vl_issue_seq_chk.sv
module vl_issue_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic illegal
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_BUSY_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready)); // R9

  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && $past(in_valid && in_ready))); // R7

  AST_ILLEGAL_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal && done)); // R8

endmodule

bind vl_issue_seq vl_issue_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .busy     (busy),
  .done     (done),
  .illegal  (illegal)
);

// File: tb/vl_issue_seq_bench.sv
`timescale 1ns/1ps
module vl_issue_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_reg = '0;
  logic [5:0]  cfg_len = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [4:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic        rf_we = 1'b0;
  logic [4:0]  rf_waddr = '0;
  logic [31:0] rf_wdata = '0;
  logic [4:0]  rf_raddr = '0;
  logic [31:0] rf_rdata;
  logic        busy, done, illegal;

  int checks = 0;
  int errors = 0;

  logic [31:0] m  [32];
  int          ml [32];

  always #4 clk = ~clk;

  vl_issue_seq u_vl_issue_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_reg(cfg_reg), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .busy(busy), .done(done), .illegal(illegal)
  );

  // op(2) rd(5) rs1(5) rs2(5) len_rd(6) len_rs1(6) len_rs2(6) req(4)
  localparam int NROW = 17;
  localparam logic [38:0] TBL [NROW] = '{
    {2'd0, 5'd1,  5'd2,  5'd3,  6'd1,  6'd1,  6'd1,  4'd2},  // R2 ADD
    {2'd1, 5'd4,  5'd5,  5'd6,  6'd1,  6'd1,  6'd1,  4'd2},  // R2 SUB
    {2'd2, 5'd7,  5'd8,  5'd9,  6'd1,  6'd1,  6'd1,  4'd2},  // R2 MUL
    {2'd3, 5'd10, 5'd11, 5'd12, 6'd1,  6'd1,  6'd1,  4'd2},  // R2 XOR
    {2'd0, 5'd16, 5'd0,  5'd8,  6'd4,  6'd4,  6'd4,  4'd3},  // R3 vector-vector
    {2'd2, 5'd20, 5'd24, 5'd2,  6'd3,  6'd3,  6'd1,  4'd4},  // R4 vector-scalar
    {2'd1, 5'd12, 5'd1,  5'd26, 6'd5,  6'd1,  6'd5,  4'd4},  // R4 scalar-vector
    {2'd0, 5'd5,  5'd10, 5'd3,  6'd1,  6'd6,  6'd1,  4'd5},  // R5 ADD reduction
    {2'd3, 5'd0,  5'd8,  5'd20, 6'd1,  6'd4,  6'd4,  4'd5},  // R5 XOR reduction, two vectors
    {2'd1, 5'd1,  5'd2,  5'd9,  6'd1,  6'd3,  6'd1,  4'd6},  // R6 SUB reduction
    {2'd0, 5'd30, 5'd0,  5'd4,  6'd3,  6'd3,  6'd3,  4'd7},  // R7 overrun
    {2'd0, 5'd4,  5'd10, 5'd2,  6'd4,  6'd3,  6'd1,  4'd8},  // R8 dest/source mismatch
    {2'd2, 5'd1,  5'd10, 5'd20, 6'd1,  6'd2,  6'd3,  4'd8},  // R8 reduction mismatch
    {2'd2, 5'd31, 5'd28, 5'd0,  6'd1,  6'd4,  6'd1,  4'd5},  // R5 MUL reduction
    {2'd0, 5'd3,  5'd2,  5'd2,  6'd4,  6'd4,  6'd4,  4'd3},  // R3 overlapping
    {2'd3, 5'd28, 5'd0,  5'd4,  6'd4,  6'd4,  6'd1,  4'd7},  // R7 ends at r31
    {2'd0, 5'd0,  5'd0,  5'd0,  6'd32, 6'd32, 6'd32, 4'd7}   // R7 whole file
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h, expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    case (o)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a * b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic model(input logic [1:0] o, input int rd, input int s1, input int s2,
                       output bit ill, output int cyc);
    int dl = ml[rd];
    int l1 = ml[s1];
    int l2 = ml[s2];
    bit rd_red = (dl == 1) && (l1 > 1 || l2 > 1);
    ill = (rd + dl > 32) || (s1 + l1 > 32) || (s2 + l2 > 32) ||
          (l1 > 1 && l2 > 1 && l1 != l2) ||
          (!rd_red && ((l1 > 1 && l1 != dl) || (l2 > 1 && l2 != dl))) ||
          (rd_red && o == 2'd1);
    cyc = 0;
    if (ill) return;
    if (rd_red) begin
      logic [31:0] acc = m[s1];
      for (int k = 1; k < l1 + l2; k++)
        acc = f(o, acc, (k < l1) ? m[s1 + k] : m[s2 + k - l1]);
      m[rd] = acc;
      cyc = l1 + l2 - 1;
    end else begin
      for (int i = 0; i < dl; i++)
        m[rd + i] = f(o, m[s1 + ((l1 > 1) ? i : 0)], m[s2 + ((l2 > 1) ? i : 0)]);
      cyc = dl;
    end
  endtask

  task automatic set_len(input int r, input int l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_reg = 5'(r); cfg_len = 6'(l);
    @(negedge clk);
    cfg_we = 1'b0;
    ml[r] = (l == 0) ? 1 : l;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 5'(a); rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
    m[a] = d;
  endtask

  task automatic cmp_all(input string req);
    int bad = 0;
    logic [31:0] act = '0, exp = '0;
    for (int i = 0; i < 32; i++) begin
      rf_raddr = 5'(i);
      #0.1;
      if (rf_rdata !== m[i] && bad == 0) begin act = rf_rdata; exp = m[i]; end
      if (rf_rdata !== m[i]) bad++;
    end
    chk(bad == 0, req, "register file contents", act, exp);
  endtask

  // poke: 0 none, 1 length write to rd while busy, 2 data write while busy
  task automatic issue(input logic [1:0] o, input int rd, input int s1, input int s2,
                       input int poke, input int paddr, input logic [31:0] pdata,
                       input string req);
    bit ill;
    int cyc, seen, rdy_bad;
    model(o, rd, s1, s2, ill, cyc);
    @(negedge clk);
    chk(in_ready === 1'b1, req, "ready before issue", 32'(in_ready), 1);
    in_valid = 1'b1; in_op = o;
    in_rd = 5'(rd); in_rs1 = 5'(s1); in_rs2 = 5'(s2);
    @(negedge clk);
    in_valid = 1'b0;
    if (ill) begin
      chk(illegal === 1'b1 && busy === 1'b0, req, "illegal pulse", {busy, illegal}, 32'b01);
      @(negedge clk);
      chk(illegal === 1'b0 && busy === 1'b0, req, "illegal one cycle", {busy, illegal}, 0);
    end else begin
      chk(illegal === 1'b0, req, "no illegal on legal issue", 32'(illegal), 0);
      if (poke == 1) begin
        cfg_we = 1'b1; cfg_reg = 5'(rd); cfg_len = 6'd1;
        ml[rd] = 1;
      end else if (poke == 2) begin
        rf_we = 1'b1; rf_waddr = 5'(paddr); rf_wdata = pdata;
      end
      seen = 0; rdy_bad = 0;
      while (busy === 1'b1 && seen < 200) begin
        if (in_ready !== 1'b0) rdy_bad++;
        seen++;
        @(negedge clk);
        cfg_we = 1'b0; rf_we = 1'b0;
      end
      chk(rdy_bad == 0, "R9", "ready low while busy", rdy_bad, 0);
      chk(seen == cyc, req, "busy cycle count", seen, cyc);
      chk(done === 1'b1, "R9", "done after last write", 32'(done), 1);
      @(negedge clk);
      chk(done === 1'b0, "R9", "done single pulse", 32'(done), 0);
    end
    cmp_all(req);
  endtask

  task automatic do_row(input logic [38:0] row);
    int rd  = int'(row[36:32]);
    int s1  = int'(row[31:27]);
    int s2  = int'(row[26:22]);
    string req = $sformatf("R%0d", row[3:0]);
    set_len(rd, int'(row[21:16]));
    set_len(s1, int'(row[15:10]));
    set_len(s2, int'(row[9:4]));
    issue(row[38:37], rd, s1, s2, 0, 0, '0, req);
    set_len(rd, 1); set_len(s1, 1); set_len(s2, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m[i] = '0; ml[i] = 1; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(in_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && illegal === 1'b0,
        "R1", "control outputs after reset", {in_ready, busy, done, illegal}, 32'b1000);
    cmp_all("R1");
    issue(2'd0, 1, 2, 3, 0, 0, '0, "R1");  // default length 1: one cycle

    for (int i = 0; i < 32; i++) wr(i, 32'(i * 37 + 5) ^ (32'(i) << 20));

    for (int r = 0; r < NROW; r++) do_row(TBL[r]);

    // R10 overlapping per-register lengths, back to back
    set_len(0, 16); set_len(7, 5);
    issue(2'd3, 7, 7, 20, 0, 0, '0, "R10");
    issue(2'd0, 0, 0, 0, 0, 0, '0, "R10");
    set_len(0, 1); set_len(7, 1);

    // R11 back to scalar, elements readable as registers
    set_len(16, 3);
    issue(2'd0, 16, 16, 16, 0, 0, '0, "R11");
    set_len(16, 1);
    issue(2'd1, 16, 17, 18, 0, 0, '0, "R11");
    rf_raddr = 5'd18;
    #0.1;
    chk(rf_rdata === m[18], "R11", "element read as scalar", rf_rdata, m[18]);

    // R12 zero length stored as one; length captured at accept
    set_len(5, 0);
    issue(2'd0, 5, 6, 7, 0, 0, '0, "R12");
    set_len(8, 4);
    issue(2'd0, 8, 8, 1, 1, 0, '0, "R12");
    issue(2'd0, 8, 8, 8, 0, 0, '0, "R12");

    // R13 data write ignored while busy, honoured when idle
    set_len(12, 3);
    issue(2'd2, 12, 12, 2, 2, 30, 32'hDEADBEEF, "R13");
    set_len(12, 1);
    wr(30, 32'h0BADF00D);
    rf_raddr = 5'd30;
    #0.1;
    chk(rf_rdata === 32'h0BADF00D, "R13", "idle write lands", rf_rdata, 32'h0BADF00D);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule